// File: doc/BRIEF.md
# Serial ADC Read Controller

This block drives a 12-bit successive-approximation converter over a three-wire link: an active-low select, a serial clock and a single data return line. Every signal on that link is generated or sampled from one system clock. When `start` arrives and the block is idle, it pulls the select low to begin a conversion. It keeps the serial clock low while it waits for the converter to finish. Two ways of waiting are available:

- In event mode, it watches for the data line to rise, which is how the converter marks the end of conversion.
- In timed mode, it counts a fixed number of system clocks.

The block then runs thirteen serial clock periods, each derived from the system clock through a half-period divider. It samples the data line on every rising edge. The first sample is the framing bit and is thrown away; the last twelve samples form the result, most significant bit first. The select line is raised on the final falling edge. After that, the select line is kept high for a minimum rest time before another conversion can start.

The result is plain unipolar binary: zero scale reads all zeros and full scale reads all ones. The result is published with a one-cycle strobe. In event mode, if the data line never rises within a bounded wait, the block abandons the conversion and raises an error flag. That flag stays set until the next accepted start.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset `adc_cs_n`=1, `adc_sclk`=0, `busy`=0, `result_valid`=0 and `eoc_error`=0. A `start` seen while idle lowers `adc_cs_n` on the next clock and raises `busy`. A `start` seen while `busy`=1 has no effect, so exactly one select fall occurs per accepted start.
- R2: `adc_sclk` stays low while `adc_cs_n` is high. It also stays low from the select fall until the conversion has ended, so no rising edge appears before the converter has finished.
- R3: With `eoc_mode`=1, clocking starts a few cycles after the synchronised data line rises, long before the timed limit. If no rise appears within `EOC_LIMIT` cycles, `eoc_error` becomes 1 and `adc_cs_n` returns high. In that case there are no serial clock edges and no `result_valid`. The next accepted start clears `eoc_error`.
- R4: With `eoc_mode`=0, the first serial rising edge comes no sooner than `CONV_CYCLES` system clocks after the select fall, whatever the data line does.
- R5: Every high phase of `adc_sclk` lasts exactly `HALF_DIV` system clocks. Every low phase between two serial periods also lasts exactly `HALF_DIV` system clocks. The default of 12 at a 50 MHz system clock gives 2.083 MHz, which is below 2.1 MHz.
- R6: A conversion has exactly 13 rising edges on `adc_sclk`. The data line is sampled at each rising edge and the first sample is discarded. `result[11]` holds the second sample and `result[0]` holds the thirteenth.
- R7: A conversion has exactly 13 falling edges on `adc_sclk`. `adc_cs_n` rises in the same clock as the 13th falling edge, so the trailing zeros the converter would shift out afterwards are never clocked into the result.
- R8: After `adc_cs_n` rises, it stays high for at least `CS_REST` system clocks before it falls again.
- R9: `result_valid` is a single-cycle pulse, given once per completed conversion in the cycle `result` takes its new value. At all other times `result` holds its value.
- R10: The code is straight binary: a converter returning all zeros yields `result`=0x000, and one returning all ones yields 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion; acted on only while idle |
| eoc_mode | input | 1 | 1 = wait for data line rise, 0 = wait a fixed time; latched at start |
| adc_dout | input | 1 | Serial data returned by the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from an accepted start until the rest time has elapsed |
| result | output | DATA_W | Last converted code, unipolar binary |
| result_valid | output | 1 | One-cycle strobe when `result` updates |
| eoc_error | output | 1 | End of conversion never seen in event mode |

## Verification
The assertions and the sampling scheme assume three things about the converter. It changes the data line only after a serial falling edge or at end of conversion. It holds the line low while the select is high. Its data settles well inside one `HALF_DIV` phase, so the two-flop synchroniser has passed the value on before the next rising edge. The bench models the converter in exactly this way: it updates the data line on the falling system clock edge that follows each serial falling edge, and drives it low whenever the select is high. The bench uses `HALF_DIV`=3, which is the smallest divider that still gives the synchroniser that margin. It then sweeps codes in both wait modes and adds a case where the converter never finishes.

// File: rtl/adc_read_pkg.sv
package adc_read_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_REST  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise
);

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d;
        s_d.stable = s_q.meta;
        s_d.prev   = s_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q    = s_q.stable;
    assign rise = s_q.stable & ~s_q.prev;

endmodule

// File: rtl/adc_half_tick.sv
module adc_half_tick #(
    parameter int HALF_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (sample) word_d = {word_q[DATA_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
    parameter int DATA_W      = 12,
    parameter int HALF_DIV    = 12,
    parameter int CONV_CYCLES = 400,
    parameter int EOC_LIMIT   = 1000,
    parameter int CS_REST     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              eoc_mode,
    input  logic              adc_dout,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              eoc_error
);

    import adc_read_pkg::*;

    localparam int FRAME    = DATA_W + 1;
    localparam int EDGE_W   = $clog2(FRAME + 1);
    localparam int WAIT_MAX = (CONV_CYCLES > EOC_LIMIT)
                              ? ((CONV_CYCLES > CS_REST) ? CONV_CYCLES : CS_REST)
                              : ((EOC_LIMIT > CS_REST) ? EOC_LIMIT : CS_REST);
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    localparam logic [EDGE_W-1:0] EDGES     = EDGE_W'(FRAME);
    localparam logic [WAIT_W-1:0] CONV_LAST = WAIT_W'(CONV_CYCLES - 1);
    localparam logic [WAIT_W-1:0] EOC_LAST  = WAIT_W'(EOC_LIMIT - 1);
    localparam logic [WAIT_W-1:0] REST_LAST = WAIT_W'(CS_REST - 1);

    typedef struct packed {
        rd_state_e         state;
        logic              cs_n;
        logic              sclk;
        logic              mode;
        logic              err;
        logic              valid;
        logic [EDGE_W-1:0] rises;
        logic [WAIT_W-1:0] wait_cnt;
        logic [DATA_W-1:0] res;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic              dout_s;
    logic              dout_rise;
    logic              tick;
    logic              sample;
    logic [DATA_W-1:0] rx_word;

    adc_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_dout),
        .q     (dout_s),
        .rise  (dout_rise)
    );

    adc_half_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.state == ST_SHIFT),
        .tick  (tick)
    );

    assign sample = (r_q.state == ST_SHIFT) && tick && !r_q.sclk;

    adc_rx_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .bit_in (dout_s),
        .word   (rx_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state    = ST_CONV;
                    r_d.cs_n     = 1'b0;
                    r_d.mode     = eoc_mode;
                    r_d.err      = 1'b0;
                    r_d.rises    = '0;
                    r_d.wait_cnt = '0;
                end
            end
            ST_CONV: begin
                r_d.wait_cnt = r_q.wait_cnt + 1'b1;
                if (r_q.mode) begin
                    if (dout_rise) begin
                        r_d.state    = ST_SHIFT;
                        r_d.wait_cnt = '0;
                    end else if (r_q.wait_cnt == EOC_LAST) begin
                        r_d.state    = ST_REST;
                        r_d.cs_n     = 1'b1;
                        r_d.err      = 1'b1;
                        r_d.wait_cnt = '0;
                    end
                end else if (r_q.wait_cnt == CONV_LAST) begin
                    r_d.state    = ST_SHIFT;
                    r_d.wait_cnt = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk  = 1'b1;
                        r_d.rises = r_q.rises + 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.rises == EDGES) begin
                            r_d.state    = ST_REST;
                            r_d.cs_n     = 1'b1;
                            r_d.res      = rx_word;
                            r_d.valid    = 1'b1;
                            r_d.wait_cnt = '0;
                        end
                    end
                end
            end
            ST_REST: begin
                r_d.wait_cnt = r_q.wait_cnt + 1'b1;
                if (r_q.wait_cnt == REST_LAST) begin
                    r_d.state    = ST_IDLE;
                    r_d.wait_cnt = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign busy         = (r_q.state != ST_IDLE);
    assign result       = r_q.res;
    assign result_valid = r_q.valid;
    assign eoc_error    = r_q.err;

    // Rest-time observer for the select line, saturating at CS_REST.
    logic [WAIT_W-1:0] cs_hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cs_hi_run <= WAIT_W'(CS_REST);
        else if (!adc_cs_n)              cs_hi_run <= '0;
        else if (cs_hi_run < WAIT_W'(CS_REST)) cs_hi_run <= cs_hi_run + 1'b1;
    end

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);                                              // R2
    AST_SCLK_LOW_CONVERTING: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CONV) |-> !adc_sclk);                                // R2
    AST_SELECT_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy);                                                  // R1
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);                                      // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));                                   // R9
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rises <= EDGES);                                                  // R6
    AST_ERROR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_error) |-> !result_valid && adc_cs_n);                      // R3
    AST_SELECT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (cs_hi_run >= WAIT_W'(CS_REST)));                 // R8

endmodule

// File: tb/sim_adc_read_ctrl.sv
module sim_adc_read_ctrl;

    localparam int DATA_W = 12;
    localparam int HALF   = 3;
    localparam int CONV   = 40;
    localparam int ELIM   = 60;
    localparam int REST   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              start;
    logic              eoc_mode;
    logic              adc_dout;
    logic              adc_cs_n;
    logic              adc_sclk;
    logic              busy;
    logic [DATA_W-1:0] result;
    logic              result_valid;
    logic              eoc_error;

    adc_read_ctrl #(
        .DATA_W      (DATA_W),
        .HALF_DIV    (HALF),
        .CONV_CYCLES (CONV),
        .EOC_LIMIT   (ELIM),
        .CS_REST     (REST)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .eoc_mode     (eoc_mode),
        .adc_dout     (adc_dout),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .busy         (busy),
        .result       (result),
        .result_valid (result_valid),
        .eoc_error    (eoc_error)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model and monitors, all on the falling system edge.
    int m_code, m_conv_time, m_cnt, m_fall;
    bit m_never;
    bit sclk_p = 1'b0, cs_p = 1'b1;
    int rises, falls, valids, cs_falls, first_dly, since, phase_len;
    int phase_bad, early, hi_len, hi_min, fall_with_cs, last_result;

    always @(negedge clk) begin
        if (adc_cs_n) hi_len++;
        if (cs_p && !adc_cs_n) begin
            cs_falls++;
            if (hi_len < hi_min) hi_min = hi_len;
            hi_len    = 0;
            since     = 0;
            first_dly = -1;
        end
        if (!adc_cs_n) since++;
        if (adc_sclk != sclk_p) begin
            if (sclk_p || falls > 0) begin
                if (phase_len != HALF) phase_bad++;
            end
            phase_len = 1;
        end else begin
            phase_len++;
        end
        if (!sclk_p && adc_sclk) begin
            rises++;
            if (first_dly < 0) first_dly = since;
            if (m_never || m_cnt < m_conv_time) early++;
        end
        if (sclk_p && !adc_sclk) begin
            falls++;
            if (adc_cs_n) fall_with_cs++;
        end
        if (result_valid) begin
            valids++;
            last_result = int'(result);
        end
        if (adc_cs_n) begin
            adc_dout = 1'b0;
            m_cnt    = 0;
            m_fall   = 0;
        end else begin
            if (m_cnt < m_conv_time) begin
                m_cnt++;
                if (m_cnt == m_conv_time && !m_never) adc_dout = 1'b1;
            end
            if (sclk_p && !adc_sclk) begin
                m_fall++;
                adc_dout = (m_fall <= 12) ? m_code[12 - m_fall] : 1'b0;
            end
        end
        sclk_p = adc_sclk;
        cs_p   = adc_cs_n;
    end

    task automatic run(input bit mode, input int code, input bit never, input bit poke);
        @(posedge clk);
        m_code = code; m_never = never; m_conv_time = mode ? 10 : 20;
        rises = 0; falls = 0; valids = 0; cs_falls = 0; phase_bad = 0;
        early = 0; hi_min = 1000000; fall_with_cs = 0; first_dly = -1;
        @(negedge clk);
        eoc_mode = mode;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(eoc_error == 1'b0, "R3 error cleared by start", int'(eoc_error), 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(posedge clk);
        chk(cs_falls == 1, "R1 one select fall per start", cs_falls, 1);
        chk(hi_min >= REST, "R8 select rest time", hi_min, REST);
        chk(early == 0, "R2 no clock before conversion end", early, 0);
        if (never) begin
            chk(eoc_error == 1'b1, "R3 timeout flag", int'(eoc_error), 1);
            chk(valids == 0, "R3 no strobe on timeout", valids, 0);
            chk(rises == 0, "R3 no clocks on timeout", rises, 0);
            chk(adc_cs_n == 1'b1, "R3 select released", int'(adc_cs_n), 1);
        end else begin
            chk(valids == 1, "R9 single strobe", valids, 1);
            chk(last_result == code, "R6 result bits", last_result, code);
            chk(int'(result) == code, "R9 result held", int'(result), code);
            chk(rises == 13, "R6 rising edge count", rises, 13);
            chk(falls == 13, "R7 falling edge count", falls, 13);
            chk(fall_with_cs == 1, "R7 select rises on last fall", fall_with_cs, 1);
            chk(phase_bad == 0, "R5 phase lengths", phase_bad, 0);
            chk(eoc_error == 1'b0, "R3 no error", int'(eoc_error), 0);
            if (mode) chk(first_dly <= 10 + HALF + 6, "R3 event start", first_dly, 10 + HALF + 6);
            else      chk(first_dly >= CONV, "R4 timed start", first_dly, CONV);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; eoc_mode = 1'b0; adc_dout = 1'b0;
        m_conv_time = 20; m_never = 1'b0; m_code = 0; m_cnt = 0; m_fall = 0;
        hi_len = 0; since = 0; phase_len = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 reset select", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0, "R1 reset clock", int'(adc_sclk), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(result_valid == 1'b0, "R1 reset strobe", int'(result_valid), 0);
        chk(eoc_error == 1'b0, "R1 reset error", int'(eoc_error), 0);

        run(1'b0, 0, 1'b0, 1'b0);
        chk(result == 12'h000, "R10 zero scale", int'(result), 0);
        run(1'b1, 4095, 1'b0, 1'b0);
        chk(result == 12'hFFF, "R10 full scale", int'(result), 4095);
        run(1'b0, 12'hA5A, 1'b0, 1'b1);
        run(1'b1, 12'h5A5, 1'b0, 1'b1);
        run(1'b1, 0, 1'b1, 1'b0);
        run(1'b1, 12'h800, 1'b0, 1'b0);
        for (int c = 1; c < 4096; c += 41) begin
            run(1'b0, c, 1'b0, 1'b0);
            run(1'b1, 4095 - c, 1'b0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule